// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Row Refresh

This block drives a single asynchronous DRAM device that stores 4-bit words and has 22 address bits. It takes one read or write at a time from a host port. The host port uses a request/ready handshake. The block splits each host address into two 11-bit halves and sends them one after the other over a shared address bus. Active-low row, column, write and output strobes frame each half, so the device needs only half the address pins.

A built-in refresh engine runs from a programmable interval timer. Each time the timer expires, a refresh becomes pending. At the next idle point it wins over any waiting host request and performs a row-only cycle on the next row in sequence. The row counter runs over every row and wraps to zero. While a refresh is pending or running, the host sees ready low and its request waits.

The device data bus is split into an output, an output-enable and an input, so the pad ring or the surrounding logic can merge them into a bidirectional bus. Strobe phase lengths are parameters.

Top module: `dram_mux_ctrl`

## Requirements
- R1: After reset, all four strobes (dramRasN, dramCasN, dramWeN, dramOeN) are high, dramDqOe is 0, rdValid is 0 and hostReady is 1.
- R2: For an accepted host access, dramAddr carries hostAddr[21:11] when dramRasN falls and hostAddr[10:0] when dramCasN falls. dramAddr stays constant while dramCasN is low, and dramCasN is low only while dramRasN is low.
- R3: In a host access, dramRasN is low for exactly RAS_CYC cycles before dramCasN falls. dramCasN then stays low for exactly CAS_CYC cycles. Once dramRasN rises, it stays high for at least PRE_CYC cycles.
- R4: In a write access, dramWeN is low, dramOeN is high, and dramDqOe is 1 with dramDqOut equal to the written data for the whole column phase. dramDqOe is 0 at every other time.
- R5: In a read access, dramOeN is low for the whole column phase and dramDqOe is 0. The device data present at the end of the column phase appears on rdData together with a one-cycle rdValid pulse. That pulse comes RAS_CYC+CAS_CYC rising edges after the accepting edge.
- R6: dramWeN and dramOeN are never low in the same cycle.
- R7: A request is taken on a rising edge where hostReq and hostReady are both 1. hostReady is never 1 while dramRasN is low. A request held high waits until it is taken, and the address and data are latched at that edge.
- R8: When the interval timer reaches refInterval it restarts, so a refresh becomes pending every refInterval+1 cycles. On an idle controller, refresh cycles therefore start exactly refInterval+1 cycles apart. At an idle point, a pending refresh is served before a waiting host request; with refInterval equal to 0, host requests are never taken.
- R9: A refresh cycle holds dramRasN low for RAS_CYC+CAS_CYC cycles with dramCasN, dramWeN and dramOeN high, drives the refresh row on dramAddr, and is followed by the precharge gap.
- R10: Refresh rows begin at 0 after reset, increase by one per refresh cycle, and wrap from 2047 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Host access request |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 22 | Word address; upper half is the row, lower half is the column |
| hostWdata | input | 4 | Write data |
| hostReady | output | 1 | Controller can take a request this cycle |
| rdData | output | 4 | Read data, valid with rdValid |
| rdValid | output | 1 | One-cycle read completion pulse |
| refInterval | input | 16 | Refresh timer limit; period is refInterval+1 cycles |
| dramAddr | output | 11 | Multiplexed row/column/refresh address |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write strobe, active low |
| dramOeN | output | 1 | Output strobe, active low |
| dramDqOut | output | 4 | Data toward the device |
| dramDqOe | output | 1 | Drive enable for dramDqOut |
| dramDqIn | input | 4 | Data from the device |

## Verification
The assertions assume that rstN is low at time zero and for at least one rising edge, and that the strobe outputs are judged only after reset. They make no assumption about dramDqIn, which matters only on the capturing edge. The host side is assumed to keep hostAddr, hostWe and hostWdata steady while hostReq waits for hostReady. The stimulus follows this by changing inputs only on falling edges and by dropping hostReq right after the accepting edge. refInterval is changed only between phases. The bench keeps it large during latency measurements, so no refresh slips in, and at 9 while refresh spacing and row order are checked.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_REF,
    ST_PRE
  } ctlState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic takeReq;   // latch host request fields
    logic selCol;    // column half on the address bus
    logic selRef;    // refresh row on the address bus
    logic driveDq;   // drive write data toward the device
    logic capRd;     // capture read data this edge
    logic refStep;   // refresh cycle completes this edge
  } dpStrobe_t;

endpackage

// File: rtl/dram_mux_ctl.sv
module dram_mux_ctl
  import dram_mux_pkg::*;
#(
  parameter int RAS_CYC = 2,
  parameter int CAS_CYC = 2,
  parameter int PRE_CYC = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostReq,
  input  logic       reqWe,
  input  logic       refPending,
  output logic       hostReady,
  output logic       rasN,
  output logic       casN,
  output logic       weN,
  output logic       oeN,
  output dpStrobe_t  strobe
);

  localparam int REF_CYC = RAS_CYC + CAS_CYC;
  localparam int LONGEST = (REF_CYC > PRE_CYC) ? REF_CYC : PRE_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  ctlState_t        state, nextState;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] phaseLim;
  logic             lastCyc;
  logic             takeReq;

  always_comb begin
    case (state)
      ST_ROW:  phaseLim = CNT_W'(RAS_CYC);
      ST_COL:  phaseLim = CNT_W'(CAS_CYC);
      ST_REF:  phaseLim = CNT_W'(REF_CYC);
      ST_PRE:  phaseLim = CNT_W'(PRE_CYC);
      default: phaseLim = CNT_W'(1);
    endcase
  end

  assign lastCyc = (phaseCnt == phaseLim - 1'b1);
  assign takeReq = (state == ST_IDLE) && !refPending && hostReq;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (refPending)   nextState = ST_REF;
        else if (hostReq) nextState = ST_ROW;
      end
      ST_ROW:  if (lastCyc) nextState = ST_COL;
      ST_COL:  if (lastCyc) nextState = ST_PRE;
      ST_REF:  if (lastCyc) nextState = ST_PRE;
      ST_PRE:  if (lastCyc) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
    end else begin
      state <= nextState;
      if (nextState != state || nextState == ST_IDLE) phaseCnt <= '0;
      else                                            phaseCnt <= phaseCnt + 1'b1;
    end
  end

  assign hostReady = (state == ST_IDLE) && !refPending;
  assign rasN      = !(state == ST_ROW || state == ST_COL || state == ST_REF);
  assign casN      = !(state == ST_COL);
  assign weN       = !(state == ST_COL && reqWe);
  assign oeN       = !(state == ST_COL && !reqWe);

  always_comb begin
    strobe.takeReq = takeReq;
    strobe.selCol  = (state == ST_COL);
    strobe.selRef  = (state == ST_REF);
    strobe.driveDq = (state == ST_COL) && reqWe;
    strobe.capRd   = (state == ST_COL) && lastCyc && !reqWe;
    strobe.refStep = (state == ST_REF) && lastCyc;
  end

endmodule

// File: rtl/dram_mux_dp.sv
module dram_mux_dp
  import dram_mux_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 4,
  parameter int REF_ROWS = 2048,
  parameter int RINT_W   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [2*ADDR_W-1:0]   hostAddr,
  input  logic                  hostWe,
  input  logic [DATA_W-1:0]     hostWdata,
  input  logic [RINT_W-1:0]     refInterval,
  input  logic [DATA_W-1:0]     dramDqIn,
  output logic [ADDR_W-1:0]     dramAddr,
  output logic [DATA_W-1:0]     dramDqOut,
  output logic                  dramDqOe,
  output logic [DATA_W-1:0]     rdData,
  output logic                  rdValid,
  output logic                  reqWe,
  output logic                  refPending
);

  logic [ADDR_W-1:0] rowQ, colQ, refRow, refRowNext;
  logic [DATA_W-1:0] wdQ;
  logic [RINT_W-1:0] tick;
  logic              tickFire;

  // Request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ  <= '0;
      colQ  <= '0;
      wdQ   <= '0;
      reqWe <= 1'b0;
    end else if (strobe.takeReq) begin
      rowQ  <= hostAddr[2*ADDR_W-1:ADDR_W];
      colQ  <= hostAddr[ADDR_W-1:0];
      wdQ   <= hostWdata;
      reqWe <= hostWe;
    end
  end

  // Address multiplexer
  always_comb begin
    if (strobe.selRef)      dramAddr = refRow;
    else if (strobe.selCol) dramAddr = colQ;
    else                    dramAddr = rowQ;
  end

  assign dramDqOut = wdQ;
  assign dramDqOe  = strobe.driveDq;

  // Read capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.capRd;
      if (strobe.capRd) rdData <= dramDqIn;
    end
  end

  // Refresh row counter: natural wrap when the row count fills the field
  generate
    if (REF_ROWS == (1 << ADDR_W)) begin : g_natWrap
      assign refRowNext = refRow + 1'b1;
    end else begin : g_cmpWrap
      assign refRowNext = (refRow == ADDR_W'(REF_ROWS - 1)) ? '0 : refRow + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)               refRow <= '0;
    else if (strobe.refStep) refRow <= refRowNext;
  end

  // Interval timer
  assign tickFire = (tick >= refInterval);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tick       <= '0;
      refPending <= 1'b0;
    end else begin
      tick <= tickFire ? '0 : tick + 1'b1;
      if (strobe.refStep) refPending <= 1'b0;
      if (tickFire)       refPending <= 1'b1;
    end
  end

endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
  import dram_mux_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 4,
  parameter int REF_ROWS = 2048,
  parameter int RINT_W   = 16,
  parameter int RAS_CYC  = 2,
  parameter int CAS_CYC  = 2,
  parameter int PRE_CYC  = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostReq,
  input  logic                hostWe,
  input  logic [2*ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0]   hostWdata,
  output logic                hostReady,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdValid,
  input  logic [RINT_W-1:0]   refInterval,
  output logic [ADDR_W-1:0]   dramAddr,
  output logic                dramRasN,
  output logic                dramCasN,
  output logic                dramWeN,
  output logic                dramOeN,
  output logic [DATA_W-1:0]   dramDqOut,
  output logic                dramDqOe,
  input  logic [DATA_W-1:0]   dramDqIn
);

  dpStrobe_t strobe;
  logic      reqWe;
  logic      refPending;

  dram_mux_ctl #(
    .RAS_CYC(RAS_CYC),
    .CAS_CYC(CAS_CYC),
    .PRE_CYC(PRE_CYC)
  ) ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .hostReq   (hostReq),
    .reqWe     (reqWe),
    .refPending(refPending),
    .hostReady (hostReady),
    .rasN      (dramRasN),
    .casN      (dramCasN),
    .weN       (dramWeN),
    .oeN       (dramOeN),
    .strobe    (strobe)
  );

  dram_mux_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REF_ROWS(REF_ROWS),
    .RINT_W  (RINT_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hostAddr   (hostAddr),
    .hostWe     (hostWe),
    .hostWdata  (hostWdata),
    .refInterval(refInterval),
    .dramDqIn   (dramDqIn),
    .dramAddr   (dramAddr),
    .dramDqOut  (dramDqOut),
    .dramDqOe   (dramDqOe),
    .rdData     (rdData),
    .rdValid    (rdValid),
    .reqWe      (reqWe),
    .refPending (refPending)
  );

endmodule

// File: rtl/dram_mux_chk.sv
module dram_mux_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] dramAddr,
  input logic              dramRasN,
  input logic              dramCasN,
  input logic              dramWeN,
  input logic              dramOeN,
  input logic              dramDqOe,
  input logic [DATA_W-1:0] dramDqOut
);

  // R6
  a_r6_we_oe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(!dramWeN && !dramOeN));

  // R2
  a_r2_cas_in_ras: assert property (@(posedge clk) disable iff (!rstN)
    !dramCasN |-> !dramRasN);

  // R2
  a_r2_col_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!dramCasN && !$past(dramCasN)) |-> $stable(dramAddr));

  // R3
  a_r3_precharge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dramRasN) |=> (dramRasN && dramCasN));

  // R4
  a_r4_write_drive: assert property (@(posedge clk) disable iff (!rstN)
    !dramWeN |-> dramDqOe);

  // R4
  a_r4_drive_only_write: assert property (@(posedge clk) disable iff (!rstN)
    dramDqOe |-> (!dramWeN && $stable(dramDqOut)) || $rose(dramDqOe));

  // R5
  a_r5_read_release: assert property (@(posedge clk) disable iff (!rstN)
    !dramOeN |-> !dramDqOe);

  // R5
  a_r5_rdvalid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R5
  a_r5_rdvalid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> $past(!dramOeN));

  // R7
  a_r7_ready_quiet: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> (dramRasN && dramCasN));

endmodule

bind dram_mux_ctrl dram_mux_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .hostReady(hostReady),
  .rdValid  (rdValid),
  .dramAddr (dramAddr),
  .dramRasN (dramRasN),
  .dramCasN (dramCasN),
  .dramWeN  (dramWeN),
  .dramOeN  (dramOeN),
  .dramDqOe (dramDqOe),
  .dramDqOut(dramDqOut)
);

// File: tb/dram_mux_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_mux_ctrl_tb_top;

  localparam int RAS_CYC = 2;
  localparam int CAS_CYC = 2;
  localparam int PRE_CYC = 1;
  localparam int NROWS   = 2048;
  localparam int RD_LAT  = RAS_CYC + CAS_CYC + 1;  // negedges after the accept edge
  localparam int REF_GAP = 10;                     // refInterval 9 -> 10 cycles

  // {we, addr[21:0], data}
  localparam logic [26:0] VEC [8] = '{
    {1'b1, 11'h7FF, 11'h7FF, 4'hA},
    {1'b1, 11'h000, 11'h001, 4'h5},
    {1'b1, 11'h2A5, 11'h35A, 4'hC},
    {1'b1, 11'h123, 11'h456, 4'h3},
    {1'b0, 11'h7FF, 11'h7FF, 4'hA},
    {1'b0, 11'h000, 11'h001, 4'h5},
    {1'b0, 11'h2A5, 11'h35A, 4'hC},
    {1'b0, 11'h123, 11'h456, 4'h3}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWe = 1'b0;
  logic [21:0] hostAddr = '0;
  logic [3:0]  hostWdata = '0;
  logic [15:0] refInterval = 16'hFFFF;
  logic        hostReady, rdValid;
  logic [3:0]  rdData, dramDqOut, dramDqIn;
  logic [10:0] dramAddr;
  logic        dramRasN, dramCasN, dramWeN, dramOeN, dramDqOe;

  always #4 clk = ~clk;

  dram_mux_ctrl dut_i (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostReady(hostReady),
    .rdData(rdData), .rdValid(rdValid), .refInterval(refInterval),
    .dramAddr(dramAddr), .dramRasN(dramRasN), .dramCasN(dramCasN),
    .dramWeN(dramWeN), .dramOeN(dramOeN), .dramDqOut(dramDqOut),
    .dramDqOe(dramDqOe), .dramDqIn(dramDqIn)
  );

  int nChecks = 0, nFail = 0;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  // Behavioural device model and pin monitor
  logic [3:0]  mem [256];
  logic [10:0] curRow = '0, curCol = '0, lastRow = '0, lastCol = '0;
  logic        prevRas = 1'b1, prevCas = 1'b1, sawCas = 1'b0;
  logic [3:0]  curWdata = '0;
  int rasLen = 0, casLen = 0, highLen = 100, cyc = 0, rasStart = 0, lastRefStart = 0;
  int excErr = 0, rdyErr = 0, timErr = 0, gapErr = 0, wrErr = 0;
  int refCount = 0, refLenErr = 0, refRowErr = 0, spaceErr = 0, spaceIdx = 0;
  int expRefRow = 0, prevRefRow = -1;
  logic wrapSeen = 1'b0, spaceOn = 1'b0;

  assign dramDqIn = (!dramOeN && !dramCasN) ? mem[{curRow[3:0], curCol[3:0]}] : 4'h0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (!dramWeN && !dramOeN) excErr++;
      if (!dramRasN && hostReady) rdyErr++;
      if (prevRas && !dramRasN) begin
        if (highLen < PRE_CYC) gapErr++;
        rasLen = 1; sawCas = 1'b0; curRow = dramAddr; rasStart = cyc;
      end else if (!dramRasN && dramCasN && !sawCas) rasLen++;
      if (prevCas && !dramCasN) begin
        if (rasLen != RAS_CYC) timErr++;
        curCol = dramAddr; sawCas = 1'b1; casLen = 1;
        lastRow = curRow; lastCol = dramAddr;
      end else if (!dramCasN) begin
        casLen++;
        if (dramAddr != curCol) timErr++;
      end
      if (!dramCasN && !dramWeN) begin
        if (!dramDqOe || dramDqOut != curWdata) wrErr++;
        mem[{curRow[3:0], curCol[3:0]}] = dramDqOut;
      end
      if (dramWeN && dramDqOe) wrErr++;
      if (!prevCas && dramCasN && casLen != CAS_CYC) timErr++;
      if (!prevRas && dramRasN) begin
        highLen = 1;
        if (!sawCas) begin
          refCount++;
          if (rasLen != RAS_CYC + CAS_CYC) refLenErr++;
          if (int'(curRow) != expRefRow) refRowErr++;
          if (prevRefRow == NROWS - 1 && curRow == 0) wrapSeen = 1'b1;
          prevRefRow = int'(curRow);
          expRefRow = (expRefRow + 1) % NROWS;
          if (spaceOn) begin
            if (spaceIdx >= 2 && rasStart - lastRefStart != REF_GAP) spaceErr++;
            spaceIdx++;
          end
          lastRefStart = rasStart;
        end
      end else if (dramRasN) highLen++;
      prevRas = dramRasN;
      prevCas = dramCasN;
    end
  end

  task automatic doAccess(input logic we, input logic [21:0] addr, input logic [3:0] d,
                          output logic [3:0] rd, output int lat);
    int guard;
    @(negedge clk);
    hostReq = 1'b1; hostWe = we; hostAddr = addr; hostWdata = d; curWdata = d;
    guard = 0;
    while (!hostReady && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
    hostReq = 1'b0;
    lat = 1; rd = '0;
    if (!we) begin
      while (!rdValid && lat < 50) begin @(negedge clk); lat++; end
      rd = rdData;
    end
    guard = 0;
    while (!hostReady && guard < 1000) begin @(negedge clk); guard++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    summary();
    $finish;
  end

  initial begin
    logic [3:0] rd;
    int lat, guard, readyHigh, refBase;
    for (int i = 0; i < 256; i++) mem[i] = 4'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rasN", dramRasN, 1);
    check("R1 casN", dramCasN, 1);
    check("R1 weN", dramWeN, 1);
    check("R1 oeN", dramOeN, 1);
    check("R1 dqOe", dramDqOe, 0);
    check("R1 rdValid", rdValid, 0);
    check("R1 hostReady", hostReady, 1);

    // Vector table: R2 address split, R4 writes, R5 reads and latency
    foreach (VEC[i]) begin
      doAccess(VEC[i][26], VEC[i][25:4], VEC[i][3:0], rd, lat);
      check("R2 row half", lastRow, VEC[i][25:15]);
      check("R2 column half", lastCol, VEC[i][14:4]);
      if (!VEC[i][26]) begin
        check("R5 read data", rd, VEC[i][3:0]);
        check("R5 rdValid latency", lat, RD_LAT);
      end
    end

    // R4 overwrite then R5 read back the newest value
    doAccess(1'b1, {11'h2A5, 11'h35A}, 4'h6, rd, lat);
    doAccess(1'b0, {11'h2A5, 11'h35A}, 4'h0, rd, lat);
    check("R4 overwrite read back", rd, 4'h6);
    check("R8 no refresh with long interval", refCount, 0);

    // R8/R9/R10 refresh walk over every row and the wrap
    @(negedge clk);
    refInterval = 16'd9;
    spaceOn = 1'b1;
    guard = 0;
    while (refCount < NROWS + 1 && guard < 60000) begin @(negedge clk); guard++; end
    spaceOn = 1'b0;
    check("R9 refresh count reached", (refCount >= NROWS + 1) ? 1 : 0, 1);
    check("R8 refresh spacing errors", spaceErr, 0);
    check("R9 refresh length errors", refLenErr, 0);
    check("R10 refresh row order errors", refRowErr, 0);
    check("R10 wrap 2047 to 0 seen", wrapSeen, 1);

    // R7 host access in between refreshes still works
    doAccess(1'b0, {11'h000, 11'h001}, 4'h0, rd, lat);
    check("R7 read during refresh traffic", rd, 4'h5);

    // R8 refresh priority: interval 0 starves the host
    @(negedge clk);
    refInterval = 16'd0;
    repeat (20) @(negedge clk);
    hostReq = 1'b1; hostWe = 1'b0; hostAddr = {11'h123, 11'h456};
    refBase = refCount; readyHigh = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (hostReady) readyHigh++;
    end
    check("R8 host held off while refresh pending", readyHigh, 0);
    check("R8 refreshes continued", (refCount - refBase >= 8) ? 1 : 0, 1);
    refInterval = 16'hFFFF;
    guard = 0;
    while (!hostReady && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    hostReq = 1'b0;
    guard = 0;
    while (!rdValid && guard < 50) begin @(negedge clk); guard++; end
    check("R7 waiting request served after refresh", rdData, 4'h3);
    repeat (10) @(negedge clk);

    // Monitors over the whole run
    check("R6 we/oe overlap cycles", excErr, 0);
    check("R7 ready while row strobe low", rdyErr, 0);
    check("R3 phase length errors", timErr, 0);
    check("R3 precharge gap errors", gapErr, 0);
    check("R4 data drive errors", wrErr, 0);
    summary();
    $finish;
  end

endmodule